// File: doc/BRIEF.md
# GPIO Port Register Controller

This block is the register front end for one 16-pin general-purpose I/O port. A processor reaches it over a simple 32-bit register bus. The block holds a 4-bit configuration field for each pin, an output data register and a synchronised view of the pin inputs. From these registers it produces flags for each pin: drive value, output enable, open-drain, pull-up, pull-down, alternate-function and analog. The pad ring and the alternate-function multiplexer consume these flags.

Output bits can be changed atomically through two write-only registers, so software never needs a read-modify-write. One register sets or clears any output bits. The other register only clears them. A lock register is armed by a fixed key sequence. Once armed, it freezes the configuration fields of a chosen set of pins until the next reset.

A bus access is presented for one cycle with `bus_sel` high. The response comes one cycle later with `bus_ack` high, together with `bus_rdata` and `bus_err`.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every pin configuration field reads 4'b0100 (input floating), so both configuration words read 32'h4444_4444. The output data register and the lock register read 0.
- R2: Register map, by byte address: 0x00 is configuration for pins 0..7, 0x04 is configuration for pins 8..15, 0x08 is input data, 0x0C is output data, 0x10 is set/clear, 0x14 is clear-only and 0x18 is lock. Unmapped addresses read 0. Pin n uses bits [4k+3:4k] of its word (k = n mod 8), with MODE in bits [1:0] and CNF in bits [3:2]. Each access is answered exactly one cycle later by `bus_ack`. Writes return 0 on `bus_rdata`.
- R3: A write to set/clear sets output bit n when bit n is 1 and clears output bit n when bit n+16 is 1. When both are 1, the set takes effect. Zero bits leave the output unchanged. The register reads 0.
- R4: A write to clear-only clears output bit n when bit n is 1. Bits 31:16 are ignored. The register reads 0.
- R5: An access with `bus_size` other than 2'b10 (word), or with `bus_addr[1:0]` not 0, changes no register. It is answered with `bus_err`=1 and `bus_rdata`=0.
- R6: Input modes (MODE=00) decode by CNF. CNF=00 is analog (`pin_an`=1). CNF=01 is floating. CNF=10 is pull: `pin_pu` follows the output data bit and `pin_pd` is its inverse. CNF=11 behaves as floating. In all input modes `pin_oe`=0.
- R7: Output modes (MODE≠00) set `pin_oe`=1. CNF=00 is push-pull, CNF=01 is open-drain (`pin_od`), CNF=10 is alternate-function push-pull (`pin_af`) and CNF=11 is alternate-function open-drain (`pin_af` and `pin_od`). `pin_out` always equals the output data register.
- R8: Input data bits [15:0] return the pins after a two-flop synchroniser. Bits of pins in analog mode read 0, and bits 31:16 read 0. Writes to the input data register are ignored.
- R9: The lock register reads {15'b0, locked, mask[15:0]}. Locking requires five accesses in order, with an unchanged mask in bits 15:0: write key bit 16 = 1, write 0, write 1, read (returns locked = 0), read (returns locked = 1). Any other access to the lock register breaks the sequence.
- R10: While locked, writes leave the configuration fields of masked pins unchanged, while unmasked fields still update. Writes to the lock register are then ignored, and only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 00 byte, 01 half-word, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after bus_sel |
| bus_rdata | output | 32 | Read data |
| bus_err | output | 1 | Error response for rejected access |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Drive value per pin |
| pin_oe | output | 16 | Output driver enable |
| pin_od | output | 16 | Open-drain select |
| pin_pu | output | 16 | Pull-up enable |
| pin_pd | output | 16 | Pull-down enable |
| pin_af | output | 16 | Alternate-function select |
| pin_an | output | 16 | Analog mode flag |

## Verification
The hardest state to reach from the ports is an armed lock. The bus must follow an exact five-step order with a steady mask, and once the lock is armed it can only be left through reset.

The stimulus first runs a sequence whose mask changes at the second step, and checks that the port stays unlocked. It then runs the full sequence and probes both locked and unlocked configuration fields. Finally it drives reset in the middle of the run to confirm the configuration is writable again.

The set-wins case of the set/clear register is reached by writing the same bit in both halves of one word.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PINS    = 16;
  localparam int NIB_W   = 4;
  localparam int CFG_W   = PINS * NIB_W;
  localparam int DATA_W  = 32;
  localparam int CFG_WORDS = CFG_W / DATA_W;
  localparam int KEY_BIT = 16;

  // register indexes (word address)
  localparam int RG_CFG_LO = 0;
  localparam int RG_CFG_HI = 1;
  localparam int RG_IDR    = 2;
  localparam int RG_ODR    = 3;
  localparam int RG_SETCLR = 4;
  localparam int RG_CLR    = 5;
  localparam int RG_LOCK   = 6;
  localparam int NREG      = 7;

  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef struct packed {
    logic oe;
    logic od;
    logic pu;
    logic pd;
    logic af;
    logic an;
  } pin_flags_t;

  // nibble = {CNF[1:0], MODE[1:0]}
  function automatic pin_flags_t decode_nibble(input logic [NIB_W-1:0] nib,
                                               input logic odr_bit);
    pin_flags_t f;
    f = '0;
    if (nib[1:0] == 2'b00) begin
      case (nib[3:2])
        2'b00:   f.an = 1'b1;
        2'b10: begin
          f.pu = odr_bit;
          f.pd = ~odr_bit;
        end
        default: ;
      endcase
    end else begin
      f.oe = 1'b1;
      f.od = nib[2];
      f.af = nib[3];
    end
    return f;
  endfunction

  function automatic logic [PINS-1:0] apply_setclr(input logic [PINS-1:0] cur,
                                                   input logic [DATA_W-1:0] w);
    return (cur & ~w[2*PINS-1:PINS]) | w[PINS-1:0];
  endfunction

  function automatic logic [PINS-1:0] apply_clr(input logic [PINS-1:0] cur,
                                                input logic [DATA_W-1:0] w);
    return cur & ~w[PINS-1:0];
  endfunction

  function automatic logic [CFG_W-1:0] expand_mask(input logic [PINS-1:0] m);
    logic [CFG_W-1:0] r;
    for (int i = 0; i < PINS; i++) r[i*NIB_W +: NIB_W] = {NIB_W{m[i]}};
    return r;
  endfunction
endpackage

// File: rtl/gpio_bus_dec.sv
module gpio_bus_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-3:0] word_idx,
  output logic [NREG-1:0]   hit
);
  localparam int IDX_W = ADDR_W - 2;

  for (genvar k = 0; k < NREG; k++) begin : g_hit
    assign hit[k] = (word_idx == IDX_W'(k));
  end
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              rd_evt,
  input  logic [KEY_BIT:0]  wdata,
  output logic              lock_on,
  output logic [PINS-1:0]   lock_mask
);
  typedef enum logic [1:0] {LK_IDLE, LK_W1, LK_W2, LK_W3} lk_state_e;
  lk_state_e st_q;

  logic            key;
  logic [PINS-1:0] m_in;
  logic            same;

  assign key  = wdata[KEY_BIT];
  assign m_in = wdata[PINS-1:0];
  assign same = (m_in == lock_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= LK_IDLE;
      lock_on   <= 1'b0;
      lock_mask <= '0;
    end else if (!lock_on) begin
      if (wr_evt) lock_mask <= m_in;
      case (st_q)
        LK_IDLE: if (wr_evt && key) st_q <= LK_W1;
        LK_W1: begin
          if (wr_evt) st_q <= (!key && same) ? LK_W2 : (key ? LK_W1 : LK_IDLE);
          else if (rd_evt) st_q <= LK_IDLE;
        end
        LK_W2: begin
          if (wr_evt) st_q <= (key && same) ? LK_W3 : (key ? LK_W1 : LK_IDLE);
          else if (rd_evt) st_q <= LK_IDLE;
        end
        LK_W3: begin
          if (wr_evt) st_q <= key ? LK_W1 : LK_IDLE;
          else if (rd_evt) begin
            // this read still returns locked=0; the next one returns 1
            lock_on <= 1'b1;
            st_q    <= LK_IDLE;
          end
        end
        default: st_q <= LK_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_WORDS-1:0] wr_word,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CFG_W-1:0]     keep_mask,
  output logic [CFG_W-1:0]     cfg_q
);
  localparam logic [NIB_W-1:0]  NIB_RST = 4'b0100;
  localparam logic [CFG_W-1:0]  CFG_RST = {PINS{NIB_RST}};

  for (genvar w = 0; w < CFG_WORDS; w++) begin : g_word
    logic [DATA_W-1:0] keep;
    assign keep = keep_mask[w*DATA_W +: DATA_W];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[w*DATA_W +: DATA_W] <= CFG_RST[w*DATA_W +: DATA_W];
      else if (wr_word[w])
        cfg_q[w*DATA_W +: DATA_W] <= (cfg_q[w*DATA_W +: DATA_W] & keep) | (wdata & ~keep);
    end
  end
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_port_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic [PINS-1:0]  odr,
  output logic [PINS-1:0]  oe,
  output logic [PINS-1:0]  od,
  output logic [PINS-1:0]  pu,
  output logic [PINS-1:0]  pd,
  output logic [PINS-1:0]  af,
  output logic [PINS-1:0]  an
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pin_flags_t f;
    assign f     = decode_nibble(cfg[p*NIB_W +: NIB_W], odr[p]);
    assign oe[p] = f.oe;
    assign od[p] = f.od;
    assign pu[p] = f.pu;
    assign pd[p] = f.pd;
    assign af[p] = f.af;
    assign an[p] = f.an;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_port_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] din,
  output logic [PINS-1:0] dout
);
  logic [PINS-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= din;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [15:0]       pin_in,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_oe,
  output logic [15:0]       pin_od,
  output logic [15:0]       pin_pu,
  output logic [15:0]       pin_pd,
  output logic [15:0]       pin_af,
  output logic [15:0]       pin_an
);
  // named events for the checker
  logic            acc_word, acc_bad;
  logic [NREG-1:0] hit, wr_evt, rd_evt;
  logic            wr_setclr_evt, wr_clr_evt;
  logic [PINS-1:0] odr_q, idr_sync, lock_mask;
  logic            lock_on;
  logic [CFG_W-1:0] cfg_q, keep_mask;
  logic [DATA_W-1:0] rd_mux;

  assign acc_word = bus_sel && (bus_size == SZ_WORD) && (bus_addr[1:0] == 2'b00);
  assign acc_bad  = bus_sel && !acc_word;

  gpio_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
    .word_idx (bus_addr[ADDR_W-1:2]),
    .hit      (hit)
  );

  assign wr_evt = {NREG{acc_word &&  bus_wr}} & hit;
  assign rd_evt = {NREG{acc_word && !bus_wr}} & hit;
  assign wr_setclr_evt = wr_evt[RG_SETCLR];
  assign wr_clr_evt    = wr_evt[RG_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odr_q <= '0;
    else if (wr_evt[RG_ODR])  odr_q <= bus_wdata[PINS-1:0];
    else if (wr_setclr_evt)   odr_q <= apply_setclr(odr_q, bus_wdata);
    else if (wr_clr_evt)      odr_q <= apply_clr(odr_q, bus_wdata);
  end

  gpio_lock_seq u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt[RG_LOCK]),
    .rd_evt    (rd_evt[RG_LOCK]),
    .wdata     (bus_wdata[KEY_BIT:0]),
    .lock_on   (lock_on),
    .lock_mask (lock_mask)
  );

  assign keep_mask = lock_on ? expand_mask(lock_mask) : '0;

  gpio_cfg_bank u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_word   ({wr_evt[RG_CFG_HI], wr_evt[RG_CFG_LO]}),
    .wdata     (bus_wdata),
    .keep_mask (keep_mask),
    .cfg_q     (cfg_q)
  );

  gpio_pin_decode u_pins (
    .cfg (cfg_q),
    .odr (odr_q),
    .oe  (pin_oe),
    .od  (pin_od),
    .pu  (pin_pu),
    .pd  (pin_pd),
    .af  (pin_af),
    .an  (pin_an)
  );

  gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_in),
    .dout  (idr_sync)
  );

  assign pin_out = odr_q;

  always_comb begin
    rd_mux = '0;
    case (1'b1)
      hit[RG_CFG_LO]: rd_mux = cfg_q[DATA_W-1:0];
      hit[RG_CFG_HI]: rd_mux = cfg_q[2*DATA_W-1:DATA_W];
      hit[RG_IDR]:    rd_mux = {{(DATA_W-PINS){1'b0}}, idr_sync & ~pin_an};
      hit[RG_ODR]:    rd_mux = {{(DATA_W-PINS){1'b0}}, odr_q};
      hit[RG_LOCK]:   rd_mux = {{(DATA_W-PINS-1){1'b0}}, lock_on, lock_mask};
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_sel;
      bus_err   <= acc_bad;
      bus_rdata <= (bus_sel && !acc_bad && !bus_wr) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic [1:0]       bus_size,
  input logic [31:0]      bus_wdata,
  input logic             bus_ack,
  input logic             bus_err,
  input logic             acc_bad,
  input logic             wr_setclr_evt,
  input logic             wr_clr_evt,
  input logic [PINS-1:0]  odr_q,
  input logic [CFG_W-1:0] cfg_q,
  input logic             lock_on,
  input logic [PINS-1:0]  lock_mask,
  input logic [PINS-1:0]  pin_oe,
  input logic [PINS-1:0]  pin_an
);
  a_r2_ack_next: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ack);
  a_r2_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ack);
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr_evt |=> ((odr_q & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0])));
  a_r3_clear_half: assert property (@(posedge clk) disable iff (!rst_n)
    wr_setclr_evt |=> ((odr_q & $past(bus_wdata[31:16]) & ~$past(bus_wdata[15:0])) == '0));
  a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_evt |=> ((odr_q & $past(bus_wdata[15:0])) == '0));
  a_r5_subword_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_size != SZ_WORD) |=> (bus_ack && bus_err));
  a_r5_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> ($stable(odr_q) && $stable(cfg_q)));
  a_r6_analog_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_an & pin_oe) == '0);
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |=> (lock_on && $stable(lock_mask)));
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_on |=> (((cfg_q ^ $past(cfg_q)) & expand_mask($past(lock_mask))) == '0));
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_sel       (bus_sel),
  .bus_size      (bus_size),
  .bus_wdata     (bus_wdata),
  .bus_ack       (bus_ack),
  .bus_err       (bus_err),
  .acc_bad       (acc_bad),
  .wr_setclr_evt (wr_setclr_evt),
  .wr_clr_evt    (wr_clr_evt),
  .odr_q         (odr_q),
  .cfg_q         (cfg_q),
  .lock_on       (lock_on),
  .lock_mask     (lock_mask),
  .pin_oe        (pin_oe),
  .pin_an        (pin_an)
);

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [1:0]  bus_size = 2'b10;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd, pin_af, pin_an;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  gpio_port_ctrl u_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
    .pin_pu(pin_pu), .pin_pd(pin_pd), .pin_af(pin_af), .pin_an(pin_an)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_IDR = 5'h08,
                         A_ODR = 5'h0C, A_SC = 5'h10, A_CLR = 5'h14, A_LCK = 5'h18;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected responses as the design acknowledges
  always @(negedge clk) begin
    if (rst_n && bus_ack) begin
      if (sb_q.size() == 0) check("R2 unexpected ack", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " data"}, bus_rdata, e.data);
        check({e.tag, " err"}, {31'd0, bus_err}, {31'd0, e.err});
      end
    end
  end

  task automatic access(input logic wr, input logic [4:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] exp,
                        input logic eerr, input string tag);
    exp_t e;
    e.data = exp; e.err = eerr; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_size = 2'b10;
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d, input string tag);
    access(1'b1, a, 2'b10, d, 32'd0, 1'b0, tag);
  endtask

  task automatic rd32(input logic [4:0] a, input logic [31:0] exp, input string tag);
    access(1'b0, a, 2'b10, 32'd0, exp, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd32(A_CLO, 32'h4444_4444, "R1 cfg lo");
    rd32(A_CHI, 32'h4444_4444, "R1 cfg hi");
    rd32(A_ODR, 32'h0, "R1 odr");
    rd32(A_LCK, 32'h0, "R1 lock");
    check("R1 oe", {16'd0, pin_oe}, 32'h0);
    rd32(5'h1C, 32'h0, "R2 unmapped");

    // R2 plain output write
    wr32(A_ODR, 32'h0000_00F0, "R2 odr wr");
    rd32(A_ODR, 32'h0000_00F0, "R2 odr rd");

    // R3 set/clear: set 8..11, clear 4
    wr32(A_SC, 32'h0010_0F00, "R3 setclr");
    rd32(A_ODR, 32'h0000_0FE0, "R3 result");
    rd32(A_SC, 32'h0, "R3 reads zero");
    wr32(A_SC, 32'h0003_0003, "R3 set wins wr");
    rd32(A_ODR, 32'h0000_0FE3, "R3 set wins");

    // R4 clear-only, upper half ignored
    wr32(A_CLR, 32'hFFFF_0100, "R4 clr wr");
    rd32(A_ODR, 32'h0000_0EE3, "R4 result");
    rd32(A_CLR, 32'h0, "R4 reads zero");

    // R5 sub-word and misaligned accesses
    access(1'b1, A_ODR, 2'b00, 32'h0, 32'h0, 1'b1, "R5 byte write");
    access(1'b1, 5'h0D, 2'b10, 32'h0, 32'h0, 1'b1, "R5 misaligned write");
    access(1'b0, A_CLO, 2'b01, 32'h0, 32'h0, 1'b1, "R5 half read");
    rd32(A_ODR, 32'h0000_0EE3, "R5 odr unchanged");

    // R6 R7 mode decode: pins 7..0 = D 9 5 1 8 8 C 0
    wr32(A_ODR, 32'h0000_0004, "R6 odr setup");
    wr32(A_CLO, 32'hD951_88C0, "R6 cfg wr");
    check("R6 an", {16'd0, pin_an}, 32'h0001);
    check("R6 pu", {16'd0, pin_pu}, 32'h0004);
    check("R6 pd", {16'd0, pin_pd}, 32'h0008);
    check("R7 oe", {16'd0, pin_oe}, 32'h00F0);
    check("R7 od", {16'd0, pin_od}, 32'h00A0);
    check("R7 af", {16'd0, pin_af}, 32'h00C0);
    check("R7 out", {16'd0, pin_out}, 32'h0004);
    wr32(A_SC, 32'h0000_0008, "R6 pull flip");
    check("R6 pu flip", {16'd0, pin_pu}, 32'h000C);
    check("R6 pd flip", {16'd0, pin_pd}, 32'h0000);

    // R8 input data with analog mask
    pin_in = 16'hA5A5;
    repeat (4) @(negedge clk);
    rd32(A_IDR, 32'h0000_A5A4, "R8 idr");
    wr32(A_IDR, 32'hFFFF_FFFF, "R8 idr write");
    rd32(A_IDR, 32'h0000_A5A4, "R8 idr unchanged");

    // R9 broken sequence (mask changes), stays unlocked
    wr32(A_LCK, 32'h0001_0003, "R9 b1");
    wr32(A_LCK, 32'h0000_0001, "R9 b2");
    wr32(A_LCK, 32'h0001_0003, "R9 b3");
    rd32(A_LCK, 32'h0000_0003, "R9 broken read");
    rd32(A_LCK, 32'h0000_0003, "R9 still unlocked");

    // R9 full sequence, mask pins 0,1
    wr32(A_LCK, 32'h0001_0003, "R9 s1");
    wr32(A_LCK, 32'h0000_0003, "R9 s2");
    wr32(A_LCK, 32'h0001_0003, "R9 s3");
    rd32(A_LCK, 32'h0000_0003, "R9 read zero");
    rd32(A_LCK, 32'h0001_0003, "R9 read one");

    // R10 locked fields frozen, others writable
    wr32(A_CLO, 32'h1111_1111, "R10 cfg wr");
    rd32(A_CLO, 32'h1111_11C0, "R10 locked nibbles kept");
    check("R10 an", {16'd0, pin_an}, 32'h0001);
    check("R10 oe", {16'd0, pin_oe}, 32'h00FC);
    wr32(A_CHI, 32'h2222_2222, "R10 hi wr");
    rd32(A_CHI, 32'h2222_2222, "R10 hi open");
    wr32(A_LCK, 32'h0000_0000, "R10 lock wr");
    rd32(A_LCK, 32'h0001_0003, "R10 lock ignores writes");

    // R10 reset releases the lock
    do_reset();
    rd32(A_LCK, 32'h0, "R10 lock cleared");
    wr32(A_CLO, 32'h1111_1111, "R10 post reset wr");
    rd32(A_CLO, 32'h1111_1111, "R10 post reset rd");

    repeat (3) @(negedge clk);
    check("R2 queue drained", sb_q.size(), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule